// File: doc/BRIEF.md
# Delayed Phase-Resync Trigger Timer

This block sits beside the control registers of a fractional-N frequency synthesizer and decides when to issue a phase-resync pulse after a new channel has been programmed. Resyncing right after a channel change is risky: a cycle slip during the settling transient undoes the phase alignment. The timer therefore waits a programmable number of reference-clock cycles, chosen to be at least the loop lock time, and only then fires the pulse.

The configuration write port carries a 12-bit field. A select bit on each configuration write decides where that field goes. With the select bit clear, the field is the fractional modulus. With it set, the field is the resync delay, stored together with a 4-bit multiplier. The total wait is the delay field times the multiplier, so a 26 MHz reference with a 1.5 ms lock time is covered by a field of 3900 and a multiplier of 10, giving 39000 cycles. The timer is built from two nested down-counters. The inner counter counts the field. The outer counter counts the inner counter's wraps.

Every port is a plain control or status pin. The block accepts a write on every cycle it is strobed and never pushes back, so there is no valid/ready handshake and no back-pressure.

Top module: `resync_delay_timer`

## Requirements
- R1: While reset is held and in the first cycle after reset, `resync_pulse` and `busy` are 0 and `modulus` is 0.
- R2: A configuration write with `cfg_dly_sel` = 0 stores `cfg_field` into `modulus`, which shows the new value from the next cycle. The stored delay and multiplier are left unchanged.
- R3: A configuration write with `cfg_dly_sel` = 1 stores `cfg_field` as the delay field and `cfg_mult` as the multiplier. `modulus` is left unchanged.
- R4: When `chan_wr` is sampled high with `resync_en` high, the countdown starts. `resync_pulse` is then high for exactly one cycle, beginning D clock edges after the accepting edge, where D = field × multiplier.
- R5: A stored delay field of 0 counts as 1, and a stored multiplier of 0 counts as 1. With both at 0, the pulse begins one edge after the accepting edge.
- R6: `busy` is high from the accepting edge until the edge at which `resync_pulse` rises. It is low while the pulse is high.
- R7: A `chan_wr` accepted during a countdown restarts the full delay from that edge. If it lands on the edge at which the pulse would have fired, that pulse is suppressed.
- R8: When `resync_en` is low, `chan_wr` is ignored: `busy` stays low and no pulse follows. If `resync_en` is sampled low during a countdown, the countdown is cancelled and no pulse follows.
- R9: A countdown uses the delay and multiplier that were stored before its accepting edge. A delay write made during the countdown, or on the same edge as the `chan_wr`, takes effect only from the next accepted `chan_wr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock; all timing is in its cycles |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_wr | input | 1 | Channel-register write strobe; arms the timer |
| resync_en | input | 1 | Resync function enable |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_dly_sel | input | 1 | 1: field goes to the delay; 0: field goes to the modulus |
| cfg_field | input | 12 | Shared modulus / delay value |
| cfg_mult | input | 4 | Delay multiplier, stored only when `cfg_dly_sel` = 1 |
| resync_pulse | output | 1 | One-cycle phase-resync trigger |
| modulus | output | 12 | Stored fractional modulus |
| busy | output | 1 | Countdown in progress |

## Verification
Two events can fall on the same edge. In the first, a new channel write arrives exactly on the edge at which the running countdown would fire. The bench arms a five-cycle delay, waits until the final counting cycle, and strobes `chan_wr` there. It then expects no pulse on that edge, `busy` still high, and a fresh five-edge wait. In the second, a delay write and a channel write are strobed together. The bench judges this case by the pulse position: the pulse must follow the previously stored delay, and the newly written delay must appear only on the following arm.

// File: rtl/resync_pkg.sv
package resync_pkg;

  // default widths of the shared delay/modulus field and the multiplier
  localparam int unsigned DEF_FIELD_W = 12;
  localparam int unsigned DEF_MULT_W  = 4;

  // destination of a configuration write
  typedef enum logic {
    CFG_TO_MOD = 1'b0,
    CFG_TO_DLY = 1'b1
  } cfg_dest_e;

endpackage

// File: rtl/resync_cfg_regs.sv
module resync_cfg_regs
  import resync_pkg::*;
#(
  parameter int unsigned FIELD_W = DEF_FIELD_W,
  parameter int unsigned MULT_W  = DEF_MULT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic               dly_sel,
  input  logic [FIELD_W-1:0] field,
  input  logic [MULT_W-1:0]  mult,
  output logic [FIELD_W-1:0] mod_q,
  output logic [FIELD_W-1:0] dly_q,
  output logic [MULT_W-1:0]  mult_q
);

  cfg_dest_e dest;
  assign dest = cfg_dest_e'(dly_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mod_q  <= '0;
      dly_q  <= '0;
      mult_q <= '0;
    end else if (wr) begin
      if (dest == CFG_TO_DLY) begin
        dly_q  <= field;
        mult_q <= mult;
      end else begin
        mod_q  <= field;
      end
    end
  end

  // R3: a delay write leaves the modulus alone
  p_mod_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && dly_sel) |=> $stable(mod_q));

  // R2: a modulus write leaves the delay and multiplier alone
  p_dly_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !dly_sel) |=> ($stable(dly_q) && $stable(mult_q)));

endmodule

// File: rtl/resync_nested_counter.sv
module resync_nested_counter #(
  parameter int unsigned FIELD_W = 12,
  parameter int unsigned MULT_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               abort,
  input  logic [FIELD_W-1:0] dly,
  input  logic [MULT_W-1:0]  mult,
  output logic               active,
  output logic               term
);

  localparam logic [FIELD_W-1:0] F_ONE = FIELD_W'(1);
  localparam logic [MULT_W-1:0]  M_ONE = MULT_W'(1);

  logic [FIELD_W-1:0] inner_q, snap_q, f_eff;
  logic [MULT_W-1:0]  outer_q, m_eff;
  logic               active_q;
  logic               at_end;

  // zero in either factor counts as one (R5)
  assign f_eff  = (dly  == '0) ? F_ONE : dly;
  assign m_eff  = (mult == '0) ? M_ONE : mult;
  assign at_end = (inner_q == F_ONE) && (outer_q == M_ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inner_q  <= '0;
      outer_q  <= '0;
      snap_q   <= '0;
      active_q <= 1'b0;
    end else if (abort) begin
      active_q <= 1'b0;
    end else if (load) begin
      inner_q  <= f_eff;
      outer_q  <= m_eff;
      snap_q   <= f_eff;
      active_q <= 1'b1;
    end else if (active_q) begin
      if (inner_q == F_ONE) begin
        if (outer_q == M_ONE) begin
          active_q <= 1'b0;
        end else begin
          inner_q <= snap_q;
          outer_q <= outer_q - M_ONE;
        end
      end else begin
        inner_q <= inner_q - F_ONE;
      end
    end
  end

  assign active = active_q;
  assign term   = active_q && at_end && !load && !abort;

  // R7: an accepted write always leaves the counter running
  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !abort) |=> active);

  // R8: a cancel always stops the counter
  p_cancel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !active);

  // R4: the inner counter never sits at zero while running
  p_inner_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (inner_q != '0 && outer_q != '0));

endmodule

// File: rtl/resync_arm_ctrl.sv
module resync_arm_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic chan_wr,
  input  logic resync_en,
  input  logic term,
  input  logic busy,
  output logic load,
  output logic abort,
  output logic pulse
);

  logic pulse_q;

  assign load  = chan_wr && resync_en;
  assign abort = !resync_en;

  always_ff @(posedge clk) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= term;
  end

  assign pulse = pulse_q;

  // R4: the pulse lasts a single cycle
  p_pulse_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);

  // R6: busy and the pulse never overlap
  p_pulse_not_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> !busy);

  // R6: a pulse only ends a countdown
  p_pulse_after_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse) |-> $past(busy));

  // R8: with the function disabled no countdown survives
  p_disabled_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !resync_en |=> (!busy && !$rose(pulse)));

endmodule

// File: rtl/resync_delay_timer.sv
module resync_delay_timer
  import resync_pkg::*;
#(
  parameter int unsigned FIELD_W = DEF_FIELD_W,
  parameter int unsigned MULT_W  = DEF_MULT_W
) (
  input  logic               clk_ref,
  input  logic               rst_n,
  input  logic               chan_wr,
  input  logic               resync_en,
  input  logic               cfg_wr,
  input  logic               cfg_dly_sel,
  input  logic [FIELD_W-1:0] cfg_field,
  input  logic [MULT_W-1:0]  cfg_mult,
  output logic               resync_pulse,
  output logic [FIELD_W-1:0] modulus,
  output logic               busy
);

  logic [FIELD_W-1:0] dly_q;
  logic [MULT_W-1:0]  mult_q;
  logic               load, abort, term, active;

  resync_cfg_regs #(.FIELD_W(FIELD_W), .MULT_W(MULT_W)) u_regs (
    .clk     (clk_ref),
    .rst_n   (rst_n),
    .wr      (cfg_wr),
    .dly_sel (cfg_dly_sel),
    .field   (cfg_field),
    .mult    (cfg_mult),
    .mod_q   (modulus),
    .dly_q   (dly_q),
    .mult_q  (mult_q)
  );

  resync_arm_ctrl u_ctrl (
    .clk       (clk_ref),
    .rst_n     (rst_n),
    .chan_wr   (chan_wr),
    .resync_en (resync_en),
    .term      (term),
    .busy      (active),
    .load      (load),
    .abort     (abort),
    .pulse     (resync_pulse)
  );

  resync_nested_counter #(.FIELD_W(FIELD_W), .MULT_W(MULT_W)) u_cnt (
    .clk    (clk_ref),
    .rst_n  (rst_n),
    .load   (load),
    .abort  (abort),
    .dly    (dly_q),
    .mult   (mult_q),
    .active (active),
    .term   (term)
  );

  assign busy = active;

  // R1: outputs quiet right after reset
  p_reset_quiet_r1: assert property (@(posedge clk_ref)
    $past(!rst_n) |-> (!resync_pulse && !busy && modulus == '0));

endmodule

// File: tb/tb_resync_delay_timer.sv
module tb_resync_delay_timer;

  logic        clk_ref = 1'b0;
  logic        rst_n;
  logic        chan_wr, resync_en, cfg_wr, cfg_dly_sel;
  logic [11:0] cfg_field;
  logic [3:0]  cfg_mult;
  logic        resync_pulse, busy;
  logic [11:0] modulus;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #5 clk_ref = ~clk_ref;

  resync_delay_timer dut (
    .clk_ref      (clk_ref),
    .rst_n        (rst_n),
    .chan_wr      (chan_wr),
    .resync_en    (resync_en),
    .cfg_wr       (cfg_wr),
    .cfg_dly_sel  (cfg_dly_sel),
    .cfg_field    (cfg_field),
    .cfg_mult     (cfg_mult),
    .resync_pulse (resync_pulse),
    .modulus      (modulus),
    .busy         (busy)
  );

  // {field, multiplier, expected edges}
  localparam int NV = 10;
  localparam logic [47:0] VEC [NV] = '{
    {12'd3,    4'd2,  32'd6},
    {12'd1,    4'd1,  32'd1},
    {12'd0,    4'd5,  32'd5},
    {12'd7,    4'd0,  32'd7},
    {12'd0,    4'd0,  32'd1},
    {12'd5,    4'd3,  32'd15},
    {12'd12,   4'd1,  32'd12},
    {12'd2,    4'd15, 32'd30},
    {12'd4095, 4'd3,  32'd12285},
    {12'd3900, 4'd10, 32'd39000}
  };

  task automatic check(input string req, input bit ok, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfg(input bit sel, input int f, input int m);
    cfg_wr = 1; cfg_dly_sel = sel; cfg_field = 12'(f); cfg_mult = 4'(m);
    @(negedge clk_ref);
    cfg_wr = 0;
  endtask

  task automatic arm();
    chan_wr = 1;
    @(negedge clk_ref);
    chan_wr = 0;
  endtask

  // called at the negedge right after the accepting edge
  task automatic measure(input int exp, input string req);
    int n = 0;
    bit seen = 0;
    bit busy_ok = 1;
    while (n <= exp + 2 && !seen) begin
      if (resync_pulse) seen = 1;
      else begin
        if (!busy) busy_ok = 0;
        @(negedge clk_ref);
        n++;
      end
    end
    check({req, " pulse position"}, seen && n == exp, n, exp);
    check("R6 busy during countdown", busy_ok, int'(busy_ok), 1);
    check("R6 busy low at pulse", !busy, int'(busy), 0);
    @(negedge clk_ref);
    check("R4 pulse one cycle", !resync_pulse, int'(resync_pulse), 0);
  endtask

  task automatic quiet(input int cycles, input string req);
    bit ok = 1;
    for (int i = 0; i < cycles; i++) begin
      if (resync_pulse || busy) ok = 0;
      @(negedge clk_ref);
    end
    check(req, ok, int'(ok), 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk_ref);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; chan_wr = 0; resync_en = 1; cfg_wr = 0;
    cfg_dly_sel = 0; cfg_field = '0; cfg_mult = '0;
    repeat (3) @(negedge clk_ref);
    check("R1 pulse in reset", !resync_pulse, int'(resync_pulse), 0);
    check("R1 busy in reset", !busy, int'(busy), 0);
    rst_n = 1;
    @(negedge clk_ref);
    check("R1 modulus after reset", modulus == 0, int'(modulus), 0);
    check("R1 busy after reset", !busy, int'(busy), 0);

    // table walk: R4 / R5
    for (int v = 0; v < NV; v++) begin
      cfg(1, int'(VEC[v][47:36]), int'(VEC[v][35:32]));
      arm();
      measure(int'(VEC[v][31:0]), (VEC[v][47:36] == 0 || VEC[v][35:32] == 0) ? "R5" : "R4");
    end

    // R2 / R3: field routing
    cfg(0, 130, 9);
    check("R2 modulus stored", modulus == 130, int'(modulus), 130);
    cfg(1, 4, 2);
    check("R3 modulus kept", modulus == 130, int'(modulus), 130);
    cfg(0, 200, 0);
    check("R2 modulus rewritten", modulus == 200, int'(modulus), 200);
    arm();
    measure(8, "R2 delay kept");

    // R7: restart mid-countdown
    cfg(1, 10, 1);
    arm();
    repeat (4) @(negedge clk_ref);
    arm();
    measure(10, "R7 restart");

    // R7: restart on the firing edge
    cfg(1, 5, 1);
    arm();
    repeat (4) @(negedge clk_ref);
    arm();
    check("R7 pulse suppressed", !resync_pulse, int'(resync_pulse), 0);
    check("R7 busy kept", busy, int'(busy), 1);
    measure(5, "R7 collide");

    // R8: disabled writes ignored, cancel mid-countdown
    resync_en = 0;
    arm();
    quiet(20, "R8 disabled write ignored");
    resync_en = 1;
    cfg(1, 10, 1);
    arm();
    repeat (3) @(negedge clk_ref);
    resync_en = 0;
    @(negedge clk_ref);
    resync_en = 1;
    quiet(15, "R8 cancel");

    // R9: delay rewrite during countdown, and same edge as arm
    cfg(1, 8, 1);
    arm();
    @(negedge clk_ref);
    cfg(1, 3, 1);
    measure(6, "R9 mid rewrite");
    cfg(1, 8, 1);
    chan_wr = 1; cfg_wr = 1; cfg_dly_sel = 1; cfg_field = 12'd2; cfg_mult = 4'd1;
    @(negedge clk_ref);
    chan_wr = 0; cfg_wr = 0;
    measure(8, "R9 same edge");
    arm();
    measure(2, "R9 next arm");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule